// File: doc/BRIEF.md
# Exception entry controller

This block sits beside a simple 32-bit in-order core and handles entry into exception, interrupt and break handlers. In a given cycle the core may present five kinds of request: an external interrupt, a hardware exception, a memory-translation fault, a software break and a hardware break. The block picks at most one of them. It then applies the whole architectural entry update at one clock edge and asserts a one-cycle redirect to the handler address.

The update has several parts. The return address is written to a link register chosen by the event class, and the core flags for delay slot and immediate prefix are cleared. The machine status word changes as follows:
- the translation and user-mode bits are saved into their shadow positions;
- the event's in-progress bit is set;
- the interrupt-enable bit is cleared when the event is an interrupt.

For exceptions, the delay-slot status bit and the saved branch target are also recorded. When no event is taken, the core may load the status word directly.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Requests are ranked, highest first: hardware break, translation fault, hardware exception, software break, interrupt. Only the highest one present is taken in a cycle, and lower ones have no effect in that cycle.
- R2: An interrupt is taken only when all of these hold: status bit 1 (interrupt enable) is set, bit 9 (exception in progress) is clear, bit 3 (break in progress) is clear, `in_dslot` is low and `after_imm` is low. Otherwise it is ignored.
- R3: On every taken event, bits 13 (translation) and 11 (user mode) of the status word are copied one place left into bits 14 and 12, and bits 13 and 11 are then cleared.
- R4: A hardware exception writes PC+4 to register 17, sets status bit 9, and redirects to VEC_BASE+0x20.
- R5: A translation fault sets status bit 9 and redirects to VEC_BASE+0x20. It writes a value to register 17 that depends on the delay-slot and prefix state:
  - PC, when neither a delay slot nor a prefix is active;
  - PC−4, in a delay slot whose branch had no prefix, or when only a prefix is active;
  - PC−8, in a delay slot whose branch had a prefix.
- R6: On a hardware exception or translation fault, `esr_ds` takes the value of `in_dslot`. When `in_dslot` is high, `btr_q` also takes `branch_target`. Other events leave both unchanged.
- R7: An interrupt writes PC to register 14, clears status bit 1, and redirects to VEC_BASE+0x10.
- R8: A hardware break writes PC to register 16, sets status bit 3, and redirects to VEC_BASE+0x18.
- R9: A software break sets status bit 3, redirects to `branch_target`, and writes no register.
- R10: `flags_clr` pulses in exactly the cycles that follow a taken hardware exception or translation fault.
- R11: When `exc_enable` is low, a hardware exception request is ignored: there is no redirect and no state change.
- R12: All effects of an event sampled at a clock edge appear right after that edge, and `redir_valid` is high for that one cycle. When no event is taken, `msr_load` writes `msr_load_val` to the status word.
- R13: After reset the status word, `esr_ds`, `btr_q` and all pulse outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_brk_req | input | 1 | Hardware break request |
| mmu_fault_req | input | 1 | Translation fault request |
| hw_exc_req | input | 1 | Hardware exception request |
| sw_brk_req | input | 1 | Software break request |
| irq_req | input | 1 | External interrupt request |
| exc_enable | input | 1 | Configuration: hardware exceptions allowed |
| cur_pc | input | 32 | PC of the current instruction |
| in_dslot | input | 1 | Current instruction sits in a branch delay slot |
| after_imm | input | 1 | Current instruction follows an immediate prefix |
| dslot_imm | input | 1 | The branch that owns the delay slot had a prefix |
| branch_target | input | 32 | Target of the pending branch |
| msr_load | input | 1 | Core writes the status word |
| msr_load_val | input | 16 | Value for that write |
| redir_valid | output | 1 | One-cycle redirect strobe |
| redir_pc | output | 32 | Handler address |
| rf_we | output | 1 | Return-address register write strobe |
| rf_addr | output | 5 | Register index for that write |
| rf_data | output | 32 | Return address |
| flags_clr | output | 1 | Clear the core's delay-slot and prefix flags |
| msr_q | output | 16 | Machine status word |
| esr_ds | output | 1 | Exception status delay-slot bit |
| btr_q | output | 32 | Saved branch target |

## Verification
The overlap of interest is between the priority arbiter and the interrupt gate. The bench drives an interrupt in the same cycle as a translation fault, and also in the cycle right after an exception has set the in-progress bit. A further variant issues the interrupt while `in_dslot` or `after_imm` is high. The bench drives random mixes of all five requests together with direct status-word loads. A behavioural reference model works out which event wins and what it writes, and it is compared with every output on every clock. The gate must still block the interrupt in the cycle after a higher-ranked event was taken.

// File: rtl/exc_entry_pkg.sv
// Shared definitions for the exception entry controller.
// Assumes a 16-bit status word with the bit positions below.
package exc_entry_pkg;
    localparam int MSR_W   = 16;
    localparam int B_IE    = 1;
    localparam int B_BIP   = 3;
    localparam int B_EIP   = 9;
    localparam int B_UM    = 11;
    localparam int B_UMS   = 12;
    localparam int B_VM    = 13;
    localparam int B_VMS   = 14;
    localparam int RA_W    = 5;
    localparam logic [RA_W-1:0] REG_IRQ = 5'd14;
    localparam logic [RA_W-1:0] REG_BRK = 5'd16;
    localparam logic [RA_W-1:0] REG_EXC = 5'd17;
    localparam logic [7:0] OFS_IRQ = 8'h10;
    localparam logic [7:0] OFS_BRK = 8'h18;
    localparam logic [7:0] OFS_EXC = 8'h20;

    typedef enum logic [2:0] {
        EV_NONE  = 3'd0,
        EV_HWBRK = 3'd1,
        EV_MMU   = 3'd2,
        EV_HWEXC = 3'd3,
        EV_SWBRK = 3'd4,
        EV_IRQ   = 3'd5
    } ev_e;
endpackage

// File: rtl/exc_arbiter.sv
// Selects at most one event per cycle by fixed rank and applies the
// interrupt gate. Purely combinational; assumes requests are level inputs.
module exc_arbiter
    import exc_entry_pkg::*;
(
    input  logic hw_brk_req,
    input  logic mmu_fault_req,
    input  logic hw_exc_req,
    input  logic sw_brk_req,
    input  logic irq_req,
    input  logic exc_enable,
    input  logic msr_ie,
    input  logic msr_eip,
    input  logic msr_bip,
    input  logic in_dslot,
    input  logic after_imm,
    output ev_e  ev_sel
);
    logic irq_ok;

    // Interrupt is acceptable only in a clean, enabled, non-nested state.
    always_comb begin
        irq_ok = irq_req && msr_ie && !msr_eip && !msr_bip && !in_dslot && !after_imm;
    end

    // Fixed-rank pick of the winning event.
    always_comb begin
        if (hw_brk_req)                     ev_sel = EV_HWBRK;
        else if (mmu_fault_req)             ev_sel = EV_MMU;
        else if (hw_exc_req && exc_enable)  ev_sel = EV_HWEXC;
        else if (sw_brk_req)                ev_sel = EV_SWBRK;
        else if (irq_ok)                    ev_sel = EV_IRQ;
        else                                ev_sel = EV_NONE;
    end
endmodule

// File: rtl/exc_retaddr.sv
// Computes the return address, its target register and the handler
// address for the selected event. Combinational; assumes word-aligned PC.
module exc_retaddr
    import exc_entry_pkg::*;
#(
    parameter int          XLEN     = 32,
    parameter logic [31:0] VEC_BASE = 32'h0000_0000
)(
    input  ev_e             ev_sel,
    input  logic [XLEN-1:0] cur_pc,
    input  logic            in_dslot,
    input  logic            after_imm,
    input  logic            dslot_imm,
    input  logic [XLEN-1:0] branch_target,
    output logic            rf_we_d,
    output logic [RA_W-1:0] rf_addr_d,
    output logic [XLEN-1:0] rf_data_d,
    output logic [XLEN-1:0] redir_pc_d
);
    localparam logic [XLEN-1:0] BASE = XLEN'(VEC_BASE);
    logic [XLEN-1:0] mmu_back;

    // Amount to step back so the faulting branch (and its prefix) re-executes.
    always_comb begin
        if (in_dslot)       mmu_back = dslot_imm ? XLEN'(8) : XLEN'(4);
        else if (after_imm) mmu_back = XLEN'(4);
        else                mmu_back = '0;
    end

    // Per-event register write and handler address.
    always_comb begin
        rf_we_d    = 1'b0;
        rf_addr_d  = '0;
        rf_data_d  = '0;
        redir_pc_d = '0;
        unique case (ev_sel)
            EV_HWBRK: begin
                rf_we_d    = 1'b1;
                rf_addr_d  = REG_BRK;
                rf_data_d  = cur_pc;
                redir_pc_d = BASE + XLEN'(OFS_BRK);
            end
            EV_MMU: begin
                rf_we_d    = 1'b1;
                rf_addr_d  = REG_EXC;
                rf_data_d  = cur_pc - mmu_back;
                redir_pc_d = BASE + XLEN'(OFS_EXC);
            end
            EV_HWEXC: begin
                rf_we_d    = 1'b1;
                rf_addr_d  = REG_EXC;
                rf_data_d  = cur_pc + XLEN'(4);
                redir_pc_d = BASE + XLEN'(OFS_EXC);
            end
            EV_SWBRK: begin
                redir_pc_d = branch_target;
            end
            EV_IRQ: begin
                rf_we_d    = 1'b1;
                rf_addr_d  = REG_IRQ;
                rf_data_d  = cur_pc;
                redir_pc_d = BASE + XLEN'(OFS_IRQ);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/exc_state.sv
// Holds the status word, delay-slot status bit, saved branch target and
// the registered pulse outputs. Assumes ev_sel is already arbitrated.
module exc_state
    import exc_entry_pkg::*;
#(
    parameter int XLEN = 32
)(
    input  logic             clk,
    input  logic             rst_n,
    input  ev_e              ev_sel,
    input  logic             in_dslot,
    input  logic [XLEN-1:0]  branch_target,
    input  logic             msr_load,
    input  logic [MSR_W-1:0] msr_load_val,
    input  logic             rf_we_d,
    input  logic [RA_W-1:0]  rf_addr_d,
    input  logic [XLEN-1:0]  rf_data_d,
    input  logic [XLEN-1:0]  redir_pc_d,
    output logic [MSR_W-1:0] msr_q,
    output logic             esr_ds,
    output logic [XLEN-1:0]  btr_q,
    output logic             redir_valid,
    output logic [XLEN-1:0]  redir_pc,
    output logic             rf_we,
    output logic [RA_W-1:0]  rf_addr,
    output logic [XLEN-1:0]  rf_data,
    output logic             flags_clr
);
    logic             is_exc;
    logic [MSR_W-1:0] msr_next;

    // Exception class: hardware exception or translation fault.
    always_comb begin
        is_exc = (ev_sel == EV_HWEXC) || (ev_sel == EV_MMU);
    end

    // Next status word: mode-bit shadowing plus per-event flags.
    always_comb begin
        msr_next = msr_q;
        if (ev_sel != EV_NONE) begin
            msr_next[B_VMS] = msr_q[B_VM];
            msr_next[B_UMS] = msr_q[B_UM];
            msr_next[B_VM]  = 1'b0;
            msr_next[B_UM]  = 1'b0;
            if (ev_sel == EV_IRQ) msr_next[B_IE] = 1'b0;
            if (is_exc) msr_next[B_EIP] = 1'b1;
            if ((ev_sel == EV_HWBRK) || (ev_sel == EV_SWBRK)) msr_next[B_BIP] = 1'b1;
        end else if (msr_load) begin
            msr_next = msr_load_val;
        end
    end

    // Architectural state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msr_q  <= '0;
            esr_ds <= 1'b0;
            btr_q  <= '0;
        end else begin
            msr_q <= msr_next;
            if (is_exc) begin
                esr_ds <= in_dslot;
                if (in_dslot) btr_q <= branch_target;
            end
        end
    end

    // One-cycle redirect, register-write and flag-clear strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redir_valid <= 1'b0;
            redir_pc    <= '0;
            rf_we       <= 1'b0;
            rf_addr     <= '0;
            rf_data     <= '0;
            flags_clr   <= 1'b0;
        end else begin
            redir_valid <= (ev_sel != EV_NONE);
            redir_pc    <= redir_pc_d;
            rf_we       <= rf_we_d;
            rf_addr     <= rf_addr_d;
            rf_data     <= rf_data_d;
            flags_clr   <= is_exc;
        end
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
// Top of the exception entry controller: arbitration, return-address
// computation and state update. Assumes the core holds its inputs stable
// across the sampling edge and acts on the redirect in the next cycle.
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int          XLEN     = 32,
    parameter logic [31:0] VEC_BASE = 32'h0000_0000
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hw_brk_req,
    input  logic             mmu_fault_req,
    input  logic             hw_exc_req,
    input  logic             sw_brk_req,
    input  logic             irq_req,
    input  logic             exc_enable,
    input  logic [XLEN-1:0]  cur_pc,
    input  logic             in_dslot,
    input  logic             after_imm,
    input  logic             dslot_imm,
    input  logic [XLEN-1:0]  branch_target,
    input  logic             msr_load,
    input  logic [MSR_W-1:0] msr_load_val,
    output logic             redir_valid,
    output logic [XLEN-1:0]  redir_pc,
    output logic             rf_we,
    output logic [RA_W-1:0]  rf_addr,
    output logic [XLEN-1:0]  rf_data,
    output logic             flags_clr,
    output logic [MSR_W-1:0] msr_q,
    output logic             esr_ds,
    output logic [XLEN-1:0]  btr_q
);
    ev_e             ev_sel;
    logic            rf_we_d;
    logic [RA_W-1:0] rf_addr_d;
    logic [XLEN-1:0] rf_data_d;
    logic [XLEN-1:0] redir_pc_d;

    exc_arbiter u_arb (
        .hw_brk_req    (hw_brk_req),
        .mmu_fault_req (mmu_fault_req),
        .hw_exc_req    (hw_exc_req),
        .sw_brk_req    (sw_brk_req),
        .irq_req       (irq_req),
        .exc_enable    (exc_enable),
        .msr_ie        (msr_q[B_IE]),
        .msr_eip       (msr_q[B_EIP]),
        .msr_bip       (msr_q[B_BIP]),
        .in_dslot      (in_dslot),
        .after_imm     (after_imm),
        .ev_sel        (ev_sel)
    );

    exc_retaddr #(.XLEN(XLEN), .VEC_BASE(VEC_BASE)) u_ret (
        .ev_sel        (ev_sel),
        .cur_pc        (cur_pc),
        .in_dslot      (in_dslot),
        .after_imm     (after_imm),
        .dslot_imm     (dslot_imm),
        .branch_target (branch_target),
        .rf_we_d       (rf_we_d),
        .rf_addr_d     (rf_addr_d),
        .rf_data_d     (rf_data_d),
        .redir_pc_d    (redir_pc_d)
    );

    exc_state #(.XLEN(XLEN)) u_st (
        .clk           (clk),
        .rst_n         (rst_n),
        .ev_sel        (ev_sel),
        .in_dslot      (in_dslot),
        .branch_target (branch_target),
        .msr_load      (msr_load),
        .msr_load_val  (msr_load_val),
        .rf_we_d       (rf_we_d),
        .rf_addr_d     (rf_addr_d),
        .rf_data_d     (rf_data_d),
        .redir_pc_d    (redir_pc_d),
        .msr_q         (msr_q),
        .esr_ds        (esr_ds),
        .btr_q         (btr_q),
        .redir_valid   (redir_valid),
        .redir_pc      (redir_pc),
        .rf_we         (rf_we),
        .rf_addr       (rf_addr),
        .rf_data       (rf_data),
        .flags_clr     (flags_clr)
    );
endmodule

// File: rtl/exc_entry_chk.sv
// Property checker for the exception entry controller, bound to the top.
module exc_entry_chk
    import exc_entry_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             hw_brk_req,
    input logic             mmu_fault_req,
    input logic             hw_exc_req,
    input logic             sw_brk_req,
    input logic             irq_req,
    input logic             exc_enable,
    input logic             redir_valid,
    input logic             rf_we,
    input logic [RA_W-1:0]  rf_addr,
    input logic             flags_clr,
    input logic [MSR_W-1:0] msr_q
);
    AST_MODE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> (!msr_q[B_VM] && !msr_q[B_UM])); // R3

    AST_MODE_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> (msr_q[B_VMS] == $past(msr_q[B_VM]) &&
                         msr_q[B_UMS] == $past(msr_q[B_UM]))); // R3

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !msr_q[B_IE] && !hw_brk_req && !mmu_fault_req &&
         !(hw_exc_req && exc_enable) && !sw_brk_req) |=> !redir_valid); // R2

    AST_EXC_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_exc_req && !exc_enable && !hw_brk_req && !mmu_fault_req &&
         !sw_brk_req && !irq_req) |=> !redir_valid); // R11

    AST_WRITE_WITH_REDIR: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> redir_valid); // R12

    AST_CLR_ON_EXC: assert property (@(posedge clk) disable iff (!rst_n)
        flags_clr |-> (redir_valid && msr_q[B_EIP] && rf_addr == REG_EXC)); // R10

    AST_IRQ_IE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (redir_valid && rf_we && rf_addr == REG_IRQ) |-> !msr_q[B_IE]); // R7
endmodule

bind exc_entry_ctrl exc_entry_chk i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .hw_brk_req    (hw_brk_req),
    .mmu_fault_req (mmu_fault_req),
    .hw_exc_req    (hw_exc_req),
    .sw_brk_req    (sw_brk_req),
    .irq_req       (irq_req),
    .exc_enable    (exc_enable),
    .redir_valid   (redir_valid),
    .rf_we         (rf_we),
    .rf_addr       (rf_addr),
    .flags_clr     (flags_clr),
    .msr_q         (msr_q)
);

// File: tb/test_exc_entry_ctrl.sv
module test_exc_entry_ctrl;
    localparam logic [31:0] VB = 32'h0000_4000;

    logic clk = 0;
    logic rst_n = 0;
    logic hw_brk_req = 0, mmu_fault_req = 0, hw_exc_req = 0, sw_brk_req = 0, irq_req = 0;
    logic exc_enable = 1;
    logic [31:0] cur_pc = 0, branch_target = 0;
    logic in_dslot = 0, after_imm = 0, dslot_imm = 0;
    logic msr_load = 0;
    logic [15:0] msr_load_val = 0;
    logic redir_valid, rf_we, flags_clr, esr_ds;
    logic [31:0] redir_pc, rf_data, btr_q;
    logic [4:0] rf_addr;
    logic [15:0] msr_q;

    int total = 0, bad = 0, cycles = 0;
    bit model_on = 0, done = 0;

    // reference model state
    logic [15:0] m_msr; logic m_ds; logic [31:0] m_btr;
    logic m_rv, m_we, m_clr; logic [31:0] m_pc, m_data; logic [4:0] m_addr;

    always #2.5 clk = ~clk;

    exc_entry_ctrl #(.VEC_BASE(VB)) i_exc_entry_ctrl (
        .clk(clk), .rst_n(rst_n), .hw_brk_req(hw_brk_req), .mmu_fault_req(mmu_fault_req),
        .hw_exc_req(hw_exc_req), .sw_brk_req(sw_brk_req), .irq_req(irq_req),
        .exc_enable(exc_enable), .cur_pc(cur_pc), .in_dslot(in_dslot), .after_imm(after_imm),
        .dslot_imm(dslot_imm), .branch_target(branch_target), .msr_load(msr_load),
        .msr_load_val(msr_load_val), .redir_valid(redir_valid), .redir_pc(redir_pc),
        .rf_we(rf_we), .rf_addr(rf_addr), .rf_data(rf_data), .flags_clr(flags_clr),
        .msr_q(msr_q), .esr_ds(esr_ds), .btr_q(btr_q));

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural reference: which event wins, and what it leaves behind.
    always @(posedge clk) begin
        int ev;  // 0 none,1 hwbrk,2 mmu,3 hwexc,4 swbrk,5 irq
        if (!rst_n) begin
            m_msr = 0; m_ds = 0; m_btr = 0; m_rv = 0; m_we = 0; m_clr = 0;
            m_pc = 0; m_data = 0; m_addr = 0;
        end else begin
            ev = 0;
            if (hw_brk_req) ev = 1;
            else if (mmu_fault_req) ev = 2;
            else if (hw_exc_req && exc_enable) ev = 3;
            else if (sw_brk_req) ev = 4;
            else if (irq_req && m_msr[1] && !m_msr[9] && !m_msr[3] && !in_dslot && !after_imm) ev = 5;
            m_rv = (ev != 0); m_we = 0; m_addr = 0; m_data = 0; m_pc = 0; m_clr = (ev == 2 || ev == 3);
            if (ev != 0) begin
                m_msr[14] = m_msr[13]; m_msr[12] = m_msr[11];
                m_msr[13] = 0; m_msr[11] = 0;
            end else if (msr_load) m_msr = msr_load_val;
            case (ev)
                1: begin m_we = 1; m_addr = 16; m_data = cur_pc; m_pc = VB + 32'h18; m_msr[3] = 1; end
                2: begin
                    m_we = 1; m_addr = 17; m_pc = VB + 32'h20; m_msr[9] = 1;
                    m_data = cur_pc;
                    if (in_dslot) m_data = cur_pc - (dslot_imm ? 8 : 4);
                    else if (after_imm) m_data = cur_pc - 4;
                end
                3: begin m_we = 1; m_addr = 17; m_data = cur_pc + 4; m_pc = VB + 32'h20; m_msr[9] = 1; end
                4: begin m_pc = branch_target; m_msr[3] = 1; end
                5: begin m_we = 1; m_addr = 14; m_data = cur_pc; m_pc = VB + 32'h10; m_msr[1] = 0; end
                default: ;
            endcase
            if (ev == 2 || ev == 3) begin
                m_ds = in_dslot;
                if (in_dslot) m_btr = branch_target;
            end
        end
    end

    // Every-clock comparison against the reference model.
    always @(negedge clk) begin
        if (model_on) begin
            chk("R1/R12", "redir_valid", {31'b0, redir_valid}, {31'b0, m_rv});
            if (m_rv) chk("R4/R5/R7/R8/R9", "redir_pc", redir_pc, m_pc);
            chk("R4/R5/R7/R8", "rf_we", {31'b0, rf_we}, {31'b0, m_we});
            if (m_we) begin
                chk("R4/R5/R7/R8", "rf_addr", {27'b0, rf_addr}, {27'b0, m_addr});
                chk("R4/R5/R7/R8", "rf_data", rf_data, m_data);
            end
            chk("R2/R3/R11/R12", "msr_q", {16'b0, msr_q}, {16'b0, m_msr});
            chk("R6", "esr_ds", {31'b0, esr_ds}, {31'b0, m_ds});
            chk("R6", "btr_q", btr_q, m_btr);
            chk("R10", "flags_clr", {31'b0, flags_clr}, {31'b0, m_clr});
        end
    end

    task automatic idle();
        hw_brk_req = 0; mmu_fault_req = 0; hw_exc_req = 0; sw_brk_req = 0; irq_req = 0;
        in_dslot = 0; after_imm = 0; dslot_imm = 0; msr_load = 0;
    endtask

    // Apply at a falling edge, outputs visible at the next falling edge.
    task automatic step();
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R13: reset state
        chk("R13", "msr after reset", {16'b0, msr_q}, 0);
        chk("R13", "redir after reset", {31'b0, redir_valid}, 0);
        chk("R13", "btr after reset", btr_q, 0);
        model_on = 1;

        // R3: load VM/UM/IE, then a hardware exception
        msr_load = 1; msr_load_val = 16'h2802; step(); idle();
        cur_pc = 32'h100; hw_exc_req = 1; step(); idle();
        chk("R3", "shadow bits", {16'b0, msr_q}, 32'h5202);
        chk("R4", "r17 = pc+4", rf_data, 32'h104);

        // R2: interrupt blocked by EIP set above
        irq_req = 1; step(); idle();
        chk("R2", "irq blocked by eip", {31'b0, redir_valid}, 0);

        // R5: MMU in delay slot whose branch had a prefix
        msr_load = 1; msr_load_val = 16'h0002; step(); idle();
        cur_pc = 32'h1000; branch_target = 32'h8888; in_dslot = 1; dslot_imm = 1;
        mmu_fault_req = 1; irq_req = 1; step(); idle();
        chk("R5", "mmu ds+imm", rf_data, 32'hFF8);
        chk("R6", "btr captured", btr_q, 32'h8888);
        chk("R1", "mmu beats irq", {27'b0, rf_addr}, 17);
        cur_pc = 32'h1000; after_imm = 1; mmu_fault_req = 1; step(); idle();
        chk("R5", "mmu after prefix", rf_data, 32'hFFC);
        chk("R6", "esr_ds cleared", {31'b0, esr_ds}, 0);

        // R11: exceptions disabled
        msr_load = 1; msr_load_val = 16'h0000; step(); idle();
        exc_enable = 0; hw_exc_req = 1; step(); idle();
        chk("R11", "disabled exc ignored", {31'b0, redir_valid}, 0);
        exc_enable = 1;

        // R2: interrupt in delay slot blocked, then taken
        msr_load = 1; msr_load_val = 16'h0002; step(); idle();
        irq_req = 1; in_dslot = 1; step(); idle();
        chk("R2", "irq blocked in dslot", {31'b0, redir_valid}, 0);
        cur_pc = 32'h200; irq_req = 1; step(); idle();
        chk("R7", "irq vector", redir_pc, VB + 32'h10);

        // R1/R8/R9: break ranking
        cur_pc = 32'h300; branch_target = 32'h777C; sw_brk_req = 1; hw_brk_req = 1; step(); idle();
        chk("R8", "hw break r16", {27'b0, rf_addr}, 16);
        sw_brk_req = 1; step(); idle();
        chk("R9", "sw break target", redir_pc, 32'h777C);
        chk("R9", "sw break no write", {31'b0, rf_we}, 0);

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            hw_brk_req    = ($urandom % 16) == 0;
            mmu_fault_req = ($urandom % 10) == 0;
            hw_exc_req    = ($urandom % 8) == 0;
            sw_brk_req    = ($urandom % 12) == 0;
            irq_req       = ($urandom % 3) == 0;
            exc_enable    = ($urandom % 4) != 0;
            in_dslot      = ($urandom % 4) == 0;
            after_imm     = ($urandom % 5) == 0;
            dslot_imm     = $urandom % 2;
            cur_pc        = $urandom & 32'hFFFF_FFFC;
            branch_target = $urandom & 32'hFFFF_FFFC;
            msr_load      = ($urandom % 3) == 0;
            msr_load_val  = 16'($urandom) & 16'h7A0A | 16'h0002;
            step();
        end
        idle(); step(); step();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule